// File: doc/BRIEF.md
# Masked Burst Address Counter

This block generates burst addresses for one port of a synchronous memory. It keeps three registers of the same width. The counter supplies the address. The mask limits which counter bits may move. The mirror remembers the most recent value written into the counter. Four active-low clocked controls and one select choose the operation on each rising clock edge:

- load an external address into the counter;
- step the counter;
- clear the counter's free bits;
- load the mask;
- restore the mask to all ones.

An asynchronous active-low master reset puts all three registers into their initial state. The release of that reset is synchronised inside the block.

The mask has the form of zero or more high zeros above one or more low ones. Bit 0 may also be zero, which makes the counter step by two. Masked counter bits never change on a step or a counter clear. When a step would carry out of the free field, the free bits are restored from the mirror instead of wrapping to zero. The counter interrupt pulses low for that event. The block takes no part in chip enables and contains no memory array.

Top module: `mbac_top`

## Requirements
- R1: While the master reset `rst_n` is low, `addr_out` is zero, the mask is all ones and `cntint_n` is high.
- R2: If `cntrst_n`=1, `ads_n`=0, `cnten_n`=0 and `cnt_sel`=1 at a rising edge, `addr_out` equals `addr_in` after that edge, and the mirror takes the same value.
- R3: If `cntrst_n`=1, `ads_n`=1 and `cnten_n`=0 at a rising edge, the free counter bits (mask bits equal to 1) advance by the weight of the lowest mask bit that is 1, and the masked bits keep their value. This applies for either value of `cnt_sel`.
- R4: If `cntrst_n`=0 and `cnt_sel`=1, the free counter bits become zero, the masked bits are kept, and the mirror takes the resulting value.
- R5: If `cntrst_n`=1, `ads_n`=0, `cnten_n`=0 and `cnt_sel`=0, the mask takes `addr_in` and the counter does not change.
- R6: If `cntrst_n`=0 and `cnt_sel`=0, the mask returns to all ones and the counter does not change.
- R7: Priority, highest first: counter or mask reset (`cntrst_n`=0), then load (`ads_n`=0 with `cnten_n`=0), then step. `ads_n` has no effect while `cnten_n`=1.
- R8: A step taken when all free bits are 1 replaces the free bits with the mirror's free bits. Steps and mask operations never change the mirror.
- R9: `cntint_n` is low for the one cycle after a rising edge on which a step was taken with all free bits at 1. At every other time it is high.
- R10: With `cntrst_n`=1 and `cnten_n`=1, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock, rising edge |
| rst_n | input | 1 | Asynchronous master reset, active low |
| ads_n | input | 1 | Address strobe, active low |
| cnten_n | input | 1 | Counter enable, active low |
| cntrst_n | input | 1 | Counter/mask reset, active low |
| cnt_sel | input | 1 | 1 = reset and load act on the counter, 0 = on the mask |
| addr_in | input | AW | External address or mask value |
| addr_out | output | AW | Current counter value |
| cntint_n | output | 1 | Counter interrupt, active low, one-cycle pulse |

## Verification
The bench builds the block with AW = 8. With this width a full-range wrap at 0xFF is reached in a few steps. A 256-value space also lets a long random run of valid masks reach every wrap and clear case many times. The directed cases use a 4-bit free field for a short wrap back to the mirror and a mask with bit 0 cleared for steps of two. They also include a single free bit, where every step is a wrap. Random masks are drawn only from the contiguous form, so every expected value stays defined.

// File: rtl/mbac_pkg.sv
package mbac_pkg;
  // Operation chosen on a clock edge, in priority order of decode
  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_CNT_CLR  = 3'd1,
    OP_MSK_SET  = 3'd2,
    OP_CNT_LOAD = 3'd3,
    OP_MSK_LOAD = 3'd4,
    OP_STEP     = 3'd5
  } mbac_op_e;
endpackage

// File: rtl/mbac_rst_sync.sv
module mbac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/mbac_decode.sv
module mbac_decode
  import mbac_pkg::*;
(
  input  logic     ads_n,
  input  logic     cnten_n,
  input  logic     cntrst_n,
  input  logic     cnt_sel,
  output mbac_op_e op
);
  always_comb begin
    if (!cntrst_n)                op = cnt_sel ? OP_CNT_CLR  : OP_MSK_SET;
    else if (!cnten_n && !ads_n)  op = cnt_sel ? OP_CNT_LOAD : OP_MSK_LOAD;
    else if (!cnten_n)            op = OP_STEP;
    else                          op = OP_IDLE;
  end
endmodule

// File: rtl/mbac_next.sv
module mbac_next
  import mbac_pkg::*;
#(
  parameter int AW = 18
) (
  input  mbac_op_e      op,
  input  logic [AW-1:0] cnt_q,
  input  logic [AW-1:0] msk_q,
  input  logic [AW-1:0] mir_q,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] cnt_d,
  output logic [AW-1:0] msk_d,
  output logic [AW-1:0] mir_d,
  output logic          cnt_en,
  output logic          msk_en,
  output logic          mir_en,
  output logic          wrap_hit
);
  logic [AW-1:0] step_w;
  logic [AW-1:0] free_q;
  logic [AW-1:0] free_inc;
  logic          field_full;

  assign step_w     = msk_q & (~msk_q + AW'(1));
  assign free_q     = cnt_q & msk_q;
  assign free_inc   = (free_q + step_w) & msk_q;
  assign field_full = (free_q == msk_q);

  always_comb begin
    cnt_d    = cnt_q;
    msk_d    = msk_q;
    mir_d    = mir_q;
    cnt_en   = 1'b0;
    msk_en   = 1'b0;
    mir_en   = 1'b0;
    wrap_hit = 1'b0;
    case (op)
      OP_CNT_CLR: begin
        cnt_d  = cnt_q & ~msk_q;
        mir_d  = cnt_q & ~msk_q;
        cnt_en = 1'b1;
        mir_en = 1'b1;
      end
      OP_MSK_SET: begin
        msk_d  = '1;
        msk_en = 1'b1;
      end
      OP_CNT_LOAD: begin
        cnt_d  = addr_in;
        mir_d  = addr_in;
        cnt_en = 1'b1;
        mir_en = 1'b1;
      end
      OP_MSK_LOAD: begin
        msk_d  = addr_in;
        msk_en = 1'b1;
      end
      OP_STEP: begin
        cnt_en   = 1'b1;
        wrap_hit = field_full;
        cnt_d    = field_full ? ((cnt_q & ~msk_q) | (mir_q & msk_q))
                              : ((cnt_q & ~msk_q) | free_inc);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mbac_top.sv
module mbac_top
  import mbac_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ads_n,
  input  logic          cnten_n,
  input  logic          cntrst_n,
  input  logic          cnt_sel,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic          cntint_n
);
  logic          srst_n;
  mbac_op_e      op;
  logic [AW-1:0] cnt_q, msk_q, mir_q;
  logic [AW-1:0] cnt_d, msk_d, mir_d;
  logic          cnt_en, msk_en, mir_en, wrap_hit;
  logic          cntint_q;

  mbac_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  mbac_decode u_dec (
    .ads_n(ads_n), .cnten_n(cnten_n), .cntrst_n(cntrst_n),
    .cnt_sel(cnt_sel), .op(op)
  );

  mbac_next #(.AW(AW)) u_next (
    .op(op), .cnt_q(cnt_q), .msk_q(msk_q), .mir_q(mir_q), .addr_in(addr_in),
    .cnt_d(cnt_d), .msk_d(msk_d), .mir_d(mir_d),
    .cnt_en(cnt_en), .msk_en(msk_en), .mir_en(mir_en), .wrap_hit(wrap_hit)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q    <= '0;
      msk_q    <= '1;
      mir_q    <= '0;
      cntint_q <= 1'b1;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (msk_en) msk_q <= msk_d;
      if (mir_en) mir_q <= mir_d;
      cntint_q <= ~wrap_hit;
    end
  end

  assign addr_out = cnt_q;
  assign cntint_n = cntint_q;

  // R2: a counter load shows the external address one edge later
  assert_load_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (cntrst_n && !ads_n && !cnten_n && cnt_sel) |=> (addr_out == $past(addr_in)));

  // R5, R6: mask operations leave the counter alone
  assert_mask_ops_keep_counter_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (!cnt_sel && (!cntrst_n || (!ads_n && !cnten_n))) |=> $stable(addr_out));

  // R4: a counter clear leaves no free bit set
  assert_clear_free_bits_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (cnt_sel && !cntrst_n) |=> ((addr_out & $past(msk_q)) == '0));

  // R10: idle edges hold the counter
  assert_hold_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (cntrst_n && cnten_n) |=> $stable(addr_out));

  // R9: the interrupt only follows a step
  assert_int_after_step_R9: assert property (@(posedge clk) disable iff (!srst_n)
    !cntint_n |-> $past(cntrst_n && !cnten_n && ads_n));

  // R8: the mirror never moves on a step
  assert_mirror_stable_on_step_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (cntrst_n && !cnten_n && ads_n) |=> $stable(mir_q));
endmodule

// File: tb/mbac_top_test.sv
module mbac_top_test;
  localparam int AW = 8;
  localparam int LIM = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ads_n, cnten_n, cntrst_n, cnt_sel;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;
  logic          cntint_n;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // behavioural reference state
  int m_cnt, m_msk, m_mir, m_int;

  always #5 clk = ~clk;

  mbac_top #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .cnten_n(cnten_n),
    .cntrst_n(cntrst_n), .cnt_sel(cnt_sel), .addr_in(addr_in),
    .addr_out(addr_out), .cntint_n(cntint_n)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // reference for one edge, written from the requirements
  task automatic model(bit a, bit e, bit r, bit s, int d);
    int low, free;
    m_int = 1;
    if (!r) begin
      if (s) begin m_cnt = m_cnt & ~m_msk & (LIM-1); m_mir = m_cnt; end // R4
      else m_msk = LIM-1;                                               // R6
    end else if (!e && !a) begin
      if (s) begin m_cnt = d; m_mir = d; end                            // R2
      else m_msk = d;                                                   // R5
    end else if (!e) begin                                              // R3
      low = 0;
      for (int b = AW-1; b >= 0; b--) if (m_msk[b]) low = 1 << b;
      free = m_cnt & m_msk;
      if (free == m_msk) begin                                          // R8, R9
        m_cnt = (m_cnt & ~m_msk & (LIM-1)) | (m_mir & m_msk);
        m_int = 0;
      end else begin
        m_cnt = (m_cnt & ~m_msk & (LIM-1)) | ((free + low) & m_msk);
      end
    end
  endtask

  task automatic op(string req, bit a, bit e, bit r, bit s, int d);
    ads_n = a; cnten_n = e; cntrst_n = r; cnt_sel = s; addr_in = AW'(d);
    model(a, e, r, s, d);
    @(posedge clk);
    @(negedge clk);
    check(req, int'(addr_out), m_cnt);
    check({req, "_int"}, int'(cntint_n), m_int);
  endtask

  task automatic idle(string req);   op(req, 1, 1, 1, 1, 0); endtask
  task automatic load(int v);        op("R2", 0, 0, 1, 1, v); endtask
  task automatic step(string req);   op(req, 1, 0, 1, 1, 0); endtask
  task automatic mload(int v);       op("R5", 0, 0, 1, 0, v); endtask

  initial begin
    ads_n = 1; cnten_n = 1; cntrst_n = 1; cnt_sel = 1; addr_in = '0;
    rst_n = 0;
    m_cnt = 0; m_msk = LIM-1; m_mir = 0; m_int = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", int'(addr_out), 0);
    check("R1", int'(cntint_n), 1);
    rst_n = 1;
    repeat (3) idle("R1");
    step("R1");                 // full mask after reset: 0 -> 1
    // R2, R3: load then plain steps
    load(8'h10);
    repeat (5) step("R3");
    // R10, R7: strobe ignored while counter enable is high
    op("R10", 0, 1, 1, 1, 8'hAA);
    op("R7", 1, 1, 1, 1, 8'h55);
    // R8, R9: four free bits, wrap back to mirror
    mload(8'h0F);
    step("R5");                 // step after mask load: 0x15 -> 0x16
    load(8'h3C);
    repeat (6) step("R8");      // 3D 3E 3F then wrap to 3C with pulse
    // R3: bit 0 masked, step of two
    mload(8'h0E);
    load(8'h21);
    repeat (9) step("R3");
    // R4: clear free bits, mirror follows
    load(8'h5B);
    op("R4", 1, 1, 0, 1, 0);
    repeat (9) step("R4");
    // R7: reset beats load and step
    op("R7", 0, 0, 0, 1, 8'hFF);
    op("R7", 1, 0, 0, 1, 0);
    // R6: mask reset, counter kept, full range wrap
    op("R6", 0, 0, 0, 0, 8'h33);
    load(8'hFE);
    repeat (4) step("R6");
    // R8: single free bit, every step wraps
    mload(8'h01);
    load(8'h41);
    repeat (3) step("R8");
    // R7: mask load with mask select does not load counter
    op("R7", 0, 0, 1, 0, 8'h07);
    repeat (10) step("R3");
    // random run with contiguous masks only
    for (int i = 0; i < 600; i++) begin
      int k = $urandom_range(0, 9);
      if (k == 0) begin
        int hi = $urandom_range(0, AW-1);
        int lo = $urandom_range(0, 1);
        int mv = ((2 << hi) - 1) & ~lo;
        if (mv == 0) mv = 1;
        mload(mv);
      end
      else if (k == 1) load($urandom_range(0, LIM-1));
      else if (k == 2) op("R4", 1, $urandom_range(0, 1), 0, 1, 0);
      else if (k == 3) op("R6", $urandom_range(0, 1), 1, 0, 0, 0);
      else if (k == 4) op("R10", $urandom_range(0, 1), 1, 1, $urandom_range(0, 1), $urandom_range(0, LIM-1));
      else step("R3");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule